// File: doc/BRIEF.md
# Up/Down Event Counter with Atomic Snapshot Capture

This block counts edges of a slow external pulse input using a fast system clock. The count runs up or down, as a second external input selects. The 16-bit count is held in two chained 8-bit halves. The low half passes its carry or borrow into the high half. The count wraps at a programmable period. Both external inputs pass through a two-flop synchronizer. A control bit is XORed with the synchronized pulse level, so software chooses whether rising or falling pin edges are counted.

Software reads the count without stopping it. A read of the live low-byte register takes a snapshot of the whole count into a small capture FIFO. Software then reads the snapshot's low byte and high byte from the head of that FIFO. Both halves are copied from the same register outputs on the same clock edge. This holds even on the edge where the low half wraps and the high half steps, so a snapshot can never combine an old half with a new half.

Top module: `evcnt_snap`

## Requirements
- R1: After a synchronous active-low reset, the count is 0, the period is 0xFFFE, the edge-invert bit is 0, the FIFO is empty, the overflow flag is clear, and an empty-FIFO read returns 0.
- R2: The counter moves by exactly one on each rising edge of the synchronized pin level XORed with CTRL bit 0 (address 4). It counts up when the synchronized direction pin is 1 and down when it is 0. A pin change driven between clock edges reaches the count on the third rising clock edge.
- R3: When a capture and a count step fall on the same clock edge, the snapshot holds the count from before that step.
- R4: Counting up from a count equal to the period gives 0. Counting down from 0 gives the period.
- R5: Every snapshot is a whole count, either the count before a step or the count after it, never a mix of halves. This includes the edges where the low byte wraps from 0xFF to 0x00 or from 0x00 to 0xFF.
- R6: A read of address 0 returns the live low byte and pushes the live count into the FIFO. A read of address 7 returns the live high byte and has no side effect.
- R7: Address 1 returns the low byte of the FIFO head. Address 2 returns the high byte of the head, and reading it pops the head.
- R8: The FIFO holds 4 snapshots. A capture into a full FIFO is dropped and sets the sticky overflow flag, STATUS bit 1 (address 3). STATUS bit 0 shows that the FIFO is not empty. Writing 1 to STATUS bit 1 clears the overflow flag.
- R9: Reads of addresses 1 and 2 while the FIFO is empty return the halves of the last popped snapshot.
- R10: The period is written and read back at address 5 (low byte) and address 6 (high byte). CTRL bit 0 reads back as written.
- R11: Counting continues through captures and reads, and no edge is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_pin | input | 1 | Asynchronous pulse input to be counted |
| dir_pin | input | 1 | Asynchronous direction input, 1 = up |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Read strobe, one access per cycle |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address |

## Verification
The bench builds the block with its defaults: 8-bit halves, a 4-entry FIFO and two synchronizer stages. With 8-bit halves, a low-byte wrap is reached after a few hundred pulses. The bench drives the count to 0x1FF and sweeps single captures across each cycle around the 0x1FF/0x200 step, in both directions, so the capture edge also lands exactly on the edge where the halves change together. A period of 3 exercises the wrap in both directions within a few pulses. The 4-entry FIFO lets a burst of five captures on back-to-back cycles reach the overflow and empty-read cases.

// File: rtl/evcnt_pkg.sv
// Package: shared register address map for the event counter.
// Assumes: one register access per cycle on a simple read/write port.
package evcnt_pkg;
    typedef enum logic [2:0] {
        A_CNT_LO = 3'd0,   // live low byte, read triggers snapshot
        A_CAP_LO = 3'd1,   // snapshot head, low byte
        A_CAP_HI = 3'd2,   // snapshot head, high byte, read pops
        A_STAT   = 3'd3,   // bit0 not-empty, bit1 sticky overflow (W1C)
        A_CTRL   = 3'd4,   // bit0 edge invert
        A_PER_LO = 3'd5,   // period low byte
        A_PER_HI = 3'd6,   // period high byte
        A_CNT_HI = 3'd7    // live high byte, no side effect
    } reg_addr_e;
endpackage

// File: rtl/evcnt_sync_edge.sv
// Module: synchronizes the pulse and direction pins, applies the edge-invert
// bit, and emits a one-cycle step pulse on each rising adjusted level.
// Assumes: pins are slow relative to clk; STAGES >= 2.
module evcnt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic dir,
    input  logic invert,
    output logic step,
    output logic up
);
    logic [STAGES-1:0] pin_sh;
    logic [STAGES-1:0] dir_sh;
    logic              lvl;
    logic              prev_q;

    // Shift both pins through their synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_sh <= '0;
            dir_sh <= '0;
        end else begin
            pin_sh <= {pin_sh[STAGES-2:0], pin};
            dir_sh <= {dir_sh[STAGES-2:0], dir};
        end
    end

    assign lvl = pin_sh[STAGES-1] ^ invert;

    // Remember the adjusted level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign step = lvl & ~prev_q;
    assign up   = dir_sh[STAGES-1];

    // A step pulse never lasts two cycles (R2).
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);
endmodule

// File: rtl/evcnt_half.sv
// Module: one W-bit slice of the chained counter. It steps when enabled by the
// slice below, loads a wrap value, and reports carry or borrow upward.
// Assumes: load is only asserted together with step.
module evcnt_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         up,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         chain_in,
    output logic         chain_out,
    output logic [W-1:0] q
);
    // Update the slice on a step: wrap load, or move by one when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (step) begin
            if (load)          q <= load_val;
            else if (chain_in) q <= up ? q + 1'b1 : q - 1'b1;
        end
    end

    assign chain_out = chain_in & (up ? (&q) : ~(|q));
endmodule

// File: rtl/evcnt_capfifo.sv
// Module: snapshot FIFO. It drops pushes when full and sets a sticky overflow
// flag. It returns the last popped entry when read while empty.
// Assumes: at most one of push or pop per cycle from the register port.
module evcnt_capfifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         clr_ovf,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FIL_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [FIL_W-1:0] fill;
    logic [W-1:0]     last_q;
    logic             full, push_ok, pop_ok;

    assign full      = (fill == FIL_W'(DEPTH));
    assign not_empty = (fill != '0);
    assign push_ok   = push & ~full;
    assign pop_ok    = pop & not_empty;
    assign head      = not_empty ? mem[rd_ptr] : last_q;

    // Write a snapshot into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Advance the pointers, track the fill level and keep the last popped entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            last_q <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
                last_q <= mem[rd_ptr];
            end
            if (push_ok && !pop_ok)      fill <= fill + 1'b1;
            else if (pop_ok && !push_ok) fill <= fill - 1'b1;
        end
    end

    // Sticky overflow: set by a dropped push, cleared only on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf <= 1'b0;
        else if (push && full)     ovf <= 1'b1;
        else if (clr_ovf)          ovf <= 1'b0;
    end

    // A push into a full FIFO leaves the fill level alone (R8).
    p_drop_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(fill));
    // A dropped push raises the overflow flag (R8).
    p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ovf);
    // Overflow stays set until cleared (R8).
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);
endmodule

// File: rtl/evcnt_snap.sv
// Module: top of the up/down event counter with atomic snapshot capture.
// Chains NUM_HALVES slices into one count, wraps at the period register,
// and serves the register port.
// Assumes: register map of evcnt_pkg, two halves, HALF_W >= 2.
module evcnt_snap
    import evcnt_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_pin,
    input  logic              dir_pin,
    input  logic [2:0]        reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] reg_rdata
);
    localparam int NUM_HALVES = 2;
    localparam int CNT_W      = HALF_W * NUM_HALVES;
    localparam logic [CNT_W-1:0] PER_RST = {CNT_W{1'b1}} - 1'b1;

    logic              step, up, at_wrap, inv_q;
    logic [CNT_W-1:0]  cnt, per_q, fifo_head;
    logic [HALF_W-1:0] half_q [NUM_HALVES];
    logic [NUM_HALVES:0] chain;
    logic              cap_push, cap_pop, clr_ovf, fifo_ne, fifo_ovf;
    reg_addr_e         addr;

    assign addr = reg_addr_e'(reg_addr);

    evcnt_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .dir(dir_pin),
        .invert(inv_q), .step(step), .up(up)
    );

    assign at_wrap  = up ? (cnt == per_q) : (cnt == '0);
    assign chain[0] = 1'b1;

    // Chain the slices: each steps when every slice below it wraps.
    for (genvar gi = 0; gi < NUM_HALVES; gi++) begin : g_half
        evcnt_half #(.W(HALF_W)) u_half (
            .clk(clk), .rst_n(rst_n), .step(step), .up(up),
            .load(at_wrap),
            .load_val(up ? '0 : per_q[gi*HALF_W +: HALF_W]),
            .chain_in(chain[gi]), .chain_out(chain[gi+1]),
            .q(half_q[gi])
        );
    end

    // Gather the slice outputs into the full count.
    always_comb begin
        for (int i = 0; i < NUM_HALVES; i++) cnt[i*HALF_W +: HALF_W] = half_q[i];
    end

    // Control and period registers written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q <= 1'b0;
            per_q <= PER_RST;
        end else if (reg_wr) begin
            case (addr)
                A_CTRL:   inv_q <= reg_wdata[0];
                A_PER_LO: per_q[HALF_W-1:0] <= reg_wdata;
                A_PER_HI: per_q[CNT_W-1:HALF_W] <= reg_wdata;
                default: ;
            endcase
        end
    end

    assign cap_push = reg_rd && (addr == A_CNT_LO);
    assign cap_pop  = reg_rd && (addr == A_CAP_HI);
    assign clr_ovf  = reg_wr && (addr == A_STAT) && reg_wdata[1];

    evcnt_capfifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(cap_push), .din(cnt),
        .pop(cap_pop), .clr_ovf(clr_ovf), .head(fifo_head),
        .not_empty(fifo_ne), .ovf(fifo_ovf)
    );

    // Read data mux for the current address.
    always_comb begin
        case (addr)
            A_CNT_LO: reg_rdata = cnt[HALF_W-1:0];
            A_CNT_HI: reg_rdata = cnt[CNT_W-1:HALF_W];
            A_CAP_LO: reg_rdata = fifo_head[HALF_W-1:0];
            A_CAP_HI: reg_rdata = fifo_head[CNT_W-1:HALF_W];
            A_STAT:   reg_rdata = {{(HALF_W-2){1'b0}}, fifo_ovf, fifo_ne};
            A_CTRL:   reg_rdata = {{(HALF_W-1){1'b0}}, inv_q};
            A_PER_LO: reg_rdata = per_q[HALF_W-1:0];
            A_PER_HI: reg_rdata = per_q[CNT_W-1:HALF_W];
            default:  reg_rdata = '0;
        endcase
    end

    // Without a step pulse the count holds (R2).
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt));
    // A snapshot into an empty FIFO equals the whole pre-edge count (R3, R5).
    p_capture_atomic_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_push && !fifo_ne) |=> (fifo_head == $past(cnt)));
    // Up-count wraps to zero at the period (R4).
    p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && up && cnt == per_q) |=> (cnt == '0));
    // Down-count wraps from zero to the period (R4).
    p_wrap_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !up && cnt == '0) |=> (cnt == $past(per_q)));
endmodule

// File: tb/evcnt_snap_tb_top.sv
// Bench: behavioural reference model updated on every clock edge; every
// register read is compared with the model's prediction.
module evcnt_snap_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_pin = 1'b0;
    logic       dir_pin = 1'b1;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    evcnt_snap dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .dir_pin(dir_pin),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Reference model state.
    logic [15:0] m_cnt, m_per, m_last;
    logic        m_inv, m_ovf, m_s1, m_s2, m_d1, m_d2, m_prev;
    logic [15:0] m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 16'hFFFE; m_last = 0; m_inv = 0; m_ovf = 0;
            m_s1 = 0; m_s2 = 0; m_d1 = 0; m_d2 = 0; m_prev = 0;
            m_q.delete();
        end else begin
            logic        stp;
            logic [15:0] old;
            old = m_cnt;
            stp = (m_s2 ^ m_inv) && !m_prev;
            if (reg_rd && reg_addr == 3'd0) begin
                if (m_q.size() < 4) m_q.push_back(old); else m_ovf = 1;
            end
            if (reg_rd && reg_addr == 3'd2 && m_q.size() > 0) m_last = m_q.pop_front();
            if (stp) begin
                if (m_d2) m_cnt = (old == m_per) ? 16'd0 : old + 16'd1;
                else      m_cnt = (old == 16'd0) ? m_per : old - 16'd1;
            end
            m_prev = m_s2 ^ m_inv;
            m_s2 = m_s1; m_s1 = cnt_pin; m_d2 = m_d1; m_d1 = dir_pin;
            if (reg_wr) begin
                case (reg_addr)
                    3'd3: if (reg_wdata[1]) m_ovf = 0;
                    3'd4: m_inv = reg_wdata[0];
                    3'd5: m_per[7:0] = reg_wdata;
                    3'd6: m_per[15:8] = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] model_rdata(input logic [2:0] a);
        logic [15:0] h;
        h = (m_q.size() > 0) ? m_q[0] : m_last;
        case (a)
            3'd0: return m_cnt[7:0];
            3'd7: return m_cnt[15:8];
            3'd1: return h[7:0];
            3'd2: return h[15:8];
            3'd3: return {6'd0, m_ovf, m_q.size() > 0};
            3'd4: return {7'd0, m_inv};
            3'd5: return m_per[7:0];
            default: return m_per[15:8];
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 chk(tag, reg_rdata, model_rdata(a));
        @(posedge clk);
        #1 reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        @(negedge clk) cnt_pin = ~cnt_pin;
        idle(3);
        @(negedge clk) cnt_pin = ~cnt_pin;
        idle(3);
    endtask

    task automatic pop_both(input string tag);
        rd(3'd1, tag);
        rd(3'd2, tag);
    endtask

    // Sweep one capture across the cycles around a single count step.
    task automatic sweep_step(input logic up_dir);
        @(negedge clk) dir_pin = up_dir;
        idle(4);
        for (int d = 0; d < 7; d++) begin
            @(negedge clk) cnt_pin = 1'b1;
            idle(d);
            rd(3'd0, "R3 R5 capture at step");
            @(negedge clk) cnt_pin = 1'b0;
            idle(4);
            pop_both("R5 atomic snapshot");
            @(negedge clk) dir_pin = ~dir_pin;
            idle(4);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        rd(3'd3, "R1 status after reset");
        rd(3'd5, "R1 period low");
        rd(3'd6, "R1 period high");
        rd(3'd4, "R1 ctrl");
        rd(3'd7, "R1 count high");
        rd(3'd1, "R1 empty read low");
        rd(3'd2, "R1 empty read high");

        // R10 and R4: small period, wrap in both directions
        wr(3'd5, 8'h03); wr(3'd6, 8'h00);
        rd(3'd5, "R10 period low");
        rd(3'd6, "R10 period high");
        @(negedge clk) dir_pin = 1'b0;
        idle(4);
        pulse();
        rd(3'd0, "R4 down wrap to period");
        pop_both("R4 down wrap snapshot");
        @(negedge clk) dir_pin = 1'b1;
        idle(4);
        for (int i = 0; i < 3; i++) pulse();
        rd(3'd0, "R4 up wrap to zero");
        pop_both("R4 up wrap snapshot");

        // R2: reach 0x1FF counting up with period at max
        wr(3'd5, 8'hFE); wr(3'd6, 8'hFF);
        while (m_cnt != 16'h01FF) pulse();
        rd(3'd7, "R2 live high before wrap");
        rd(3'd0, "R2 R6 live low before wrap");
        pop_both("R6 snapshot");

        // R5: captures at every offset around the low-byte wrap
        sweep_step(1'b1);
        sweep_step(1'b0);

        // R8 and R9: burst of captures on back-to-back cycles
        for (int i = 0; i < 5; i++) rd(3'd0, "R6 burst capture");
        rd(3'd3, "R8 status full with overflow");
        for (int i = 0; i < 4; i++) pop_both("R7 pop burst");
        pop_both("R9 empty read returns last");
        rd(3'd3, "R8 overflow sticky");
        wr(3'd3, 8'h02);
        rd(3'd3, "R8 overflow cleared");

        // R2: inverted edge sense, falling edges counted
        wr(3'd4, 8'h01);
        rd(3'd4, "R10 ctrl readback");
        idle(4);
        for (int i = 0; i < 3; i++) pulse();
        rd(3'd0, "R2 inverted count");
        pop_both("R2 inverted snapshot");

        // R11: read continuously while pulses arrive
        @(negedge clk) cnt_pin = ~cnt_pin;
        for (int i = 0; i < 6; i++) begin
            rd(3'd0, "R11 capture while counting");
            pop_both("R11 snapshot while counting");
        end
        rd(3'd7, "R11 live high");
        rd(3'd0, "R11 live low");
        pop_both("R11 final");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule